// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

This block is one timer channel that runs only as a waveform generator. A single up-counter makes the time base for two pulse outputs, A and B. The counter goes back to zero on the count tick after it reaches the period value, so both outputs always have the same period. Each output has three events that can act on it: a match against its own compare value, a match against the period value, and a software trigger. For each event a two-bit action field selects none, set, clear or toggle. Normal PWM sets the output on the period match and clears it on its own compare match. Inverted PWM uses the opposite pair of actions. A constant low or constant high level comes from a software trigger with both compare actions left at none.

The counting tick comes from a prescaler on the fast clock, dividing by 2, 8, 32 or 128. It can instead come from the rising edges of a slow clock, which are synchronised into the fast domain. Software uses a simple synchronous write/read port. Through it, software sets up the mode word, the two compare values and the period, and issues commands that start the clock, stop it, or fire the software trigger.

Top module: `wave_timer_ch`

## Requirements
- R1: Register addresses are: 0 mode word (bits 15:0 read back as written, upper bits read 0); 1 compare A; 2 compare B; 3 period; 4 command (writes only; reads return the clock-running flag in bit 0); 5 current counter (read only). Other addresses read 0.
- R2: Mode bits 2:0 select the tick source. Values 0, 1, 2 and 3 give one tick every 2, 8, 32 and 128 fast cycles while the clock runs. The prescaler restarts on a software trigger, so the first tick comes that many cycles after the trigger.
- R3: On each tick the counter adds one. If the counter equals the period value at that tick, it goes to zero instead.
- R4: Action codes are 0 none, 1 set, 2 clear, 3 toggle. Output A uses mode bits 5:4 on a compare-A match, 7:6 on a period match and 9:8 on a software trigger. Output B uses bits 11:10 on a compare-B match, 13:12 on a period match and 15:14 on a software trigger. A match is counted only on a tick.
- R5: Command bit 2 is the software trigger. In the next cycle it applies each output's trigger action, sets the counter to zero and restarts the prescaler. It works whether or not the clock is running.
- R6: When both match actions of an output are none, the output keeps the level left by the last software trigger for as long as the clock runs.
- R7: Command bit 0 starts the clock and bit 1 stops it. If both are written together, stop wins. While stopped, the counter and the outputs stay the same unless a software trigger arrives. The clock-running flag is brought out on a port.
- R8: When several events hit one output in the same cycle, the software trigger wins over the period match, and the period match wins over the output's own compare match.
- R9: After reset, both outputs, the counter, the mode word, the compare values, the period and the clock-running flag are all zero.
- R10: Mode select values 4 to 7 choose the slow clock. A rising edge sampled at fast edge k gives a tick at fast edge k+2.
- R11: The counter width is a parameter of 16 or 32 bits. Compare and period writes keep only the low counter-width bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_clk | input | 1 | Slow clock, asynchronous to clk |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| wave_a_o | output | 1 | Waveform output A |
| wave_b_o | output | 1 | Waveform output B |
| cnt_o | output | CNT_W | Current counter value |
| clk_on_o | output | 1 | Clock-running flag |

## Verification
The hardest case to reach from the ports is two events landing on one output in the same tick, because the counter has to arrive at a value where a compare match and a period match coincide. A directed case sets compare A equal to the period with opposite actions and checks that the period action wins. The random phase keeps the period short, under 24, and compare values in the same range, so the model also sees coincident matches and a software trigger landing on a tick. The slow-clock path is driven by a bench slow clock that is asynchronous in ratio to the fast clock, and the count is compared against the two-stage latency.

// File: rtl/wt_pkg.sv
`timescale 1ns/1ps
package wt_pkg;
   localparam int PRE_W      = 7;   // log2 of the largest fast divider (128)
   localparam int N_DIV      = 4;   // number of fast divider choices
   localparam int MODE_W     = 16;
   localparam int SEL_W      = 3;
   localparam int ACT_BASE   = 4;   // first action field in the mode word
   localparam int ACT_STRIDE = 6;   // fields per output: compare, period, trigger
   localparam int N_OUT      = 2;

   localparam logic [2:0] ADR_MODE = 3'd0;
   localparam logic [2:0] ADR_CMPA = 3'd1;
   localparam logic [2:0] ADR_CMPB = 3'd2;
   localparam logic [2:0] ADR_PER  = 3'd3;
   localparam logic [2:0] ADR_CMD  = 3'd4;
   localparam logic [2:0] ADR_CNT  = 3'd5;

   localparam int CMD_EN  = 0;
   localparam int CMD_DIS = 1;
   localparam int CMD_SW  = 2;

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_SET  = 2'd1,
      ACT_CLR  = 2'd2,
      ACT_TGL  = 2'd3
   } act_e;

   function automatic logic act_apply(input act_e a, input logic q);
      case (a)
         ACT_SET: return 1'b1;
         ACT_CLR: return 1'b0;
         ACT_TGL: return ~q;
         default: return q;
      endcase
   endfunction
endpackage

// File: rtl/wt_tick_gen.sv
`timescale 1ns/1ps
module wt_tick_gen
   import wt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   input  logic             slow_clk,
   output logic             tick
);
   logic [PRE_W-1:0] pre_q;
   logic [2:0]       sync_q;
   logic [N_DIV-1:0] div_hit;
   logic             fast_hit;
   logic             slow_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (restart) pre_q <= '0;
      else if (run)     pre_q <= pre_q + 1'b1;
   end

   // divider j terminates when the low 2j+1 prescaler bits are all ones
   for (genvar j = 0; j < N_DIV; j++) begin : g_div
      assign div_hit[j] = &pre_q[2*j:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[1:0], slow_clk};
   end

   assign slow_rise = sync_q[1] & ~sync_q[2];
   assign fast_hit  = div_hit[sel[1:0]];
   assign tick      = run & (sel[2] ? slow_rise : fast_hit);
endmodule

// File: rtl/wt_counter.sv
`timescale 1ns/1ps
module wt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             per_hit
);
   assign per_hit = tick & (cnt == period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (per_hit) cnt <= '0;
      else if (tick)    cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/wt_wave_out.sv
`timescale 1ns/1ps
module wt_wave_out
   import wt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sw_hit,
   input  logic per_hit,
   input  logic cmp_hit,
   input  act_e sw_act,
   input  act_e per_act,
   input  act_e cmp_act,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (sw_hit)  q <= act_apply(sw_act, q);
      else if (per_hit) q <= act_apply(per_act, q);
      else if (cmp_hit) q <= act_apply(cmp_act, q);
   end
endmodule

// File: rtl/wave_timer_ch.sv
`timescale 1ns/1ps
module wave_timer_ch
   import wt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_clk,
   input  logic              bus_we,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wave_a_o,
   output logic              wave_b_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              clk_on_o
);
   if (CNT_W != 16 && CNT_W != 32) begin : g_bad_width
      $error("wave_timer_ch: CNT_W must be 16 or 32");
   end
   if (DATA_W < CNT_W || DATA_W < MODE_W) begin : g_bad_data
      $error("wave_timer_ch: DATA_W too narrow");
   end

   logic [MODE_W-1:0] mode_q;
   logic [CNT_W-1:0]  cmp_q [N_OUT];
   logic [CNT_W-1:0]  per_q;
   logic              on_q;
   logic              cmd_wr, sw_hit, tick, per_hit;
   logic [N_OUT-1:0]  wave;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata;
   assign cmd_wr = bus_we && (bus_addr == ADR_CMD);
   assign sw_hit = cmd_wr && bus_wdata[CMD_SW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         per_q  <= '0;
         on_q   <= 1'b0;
      end else begin
         if (bus_we && bus_addr == ADR_MODE) mode_q <= bus_wdata[MODE_W-1:0];
         if (bus_we && bus_addr == ADR_PER)  per_q  <= bus_wdata[CNT_W-1:0];
         if (cmd_wr) begin
            if (bus_wdata[CMD_DIS])     on_q <= 1'b0;
            else if (bus_wdata[CMD_EN]) on_q <= 1'b1;
         end
      end
   end

   wt_tick_gen u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (on_q),
      .restart  (sw_hit),
      .sel      (mode_q[SEL_W-1:0]),
      .slow_clk (slow_clk),
      .tick     (tick)
   );

   wt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .restart (sw_hit),
      .period  (per_q),
      .cnt     (cnt_o),
      .per_hit (per_hit)
   );

   for (genvar i = 0; i < N_OUT; i++) begin : g_out
      localparam int B = ACT_BASE + ACT_STRIDE * i;
      localparam logic [2:0] ADR_OWN = ADR_CMPA + 3'(i);
      logic cmp_hit;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       cmp_q[i] <= '0;
         else if (bus_we && bus_addr == ADR_OWN) cmp_q[i] <= bus_wdata[CNT_W-1:0];
      end

      assign cmp_hit = tick && (cnt_o == cmp_q[i]);

      wt_wave_out u_out (
         .clk     (clk),
         .rst_n   (rst_n),
         .sw_hit  (sw_hit),
         .per_hit (per_hit),
         .cmp_hit (cmp_hit),
         .sw_act  (act_e'(mode_q[B+5:B+4])),
         .per_act (act_e'(mode_q[B+3:B+2])),
         .cmp_act (act_e'(mode_q[B+1:B])),
         .q       (wave[i])
      );
   end

   assign wave_a_o = wave[0];
   assign wave_b_o = wave[1];
   assign clk_on_o = on_q;

   always_comb begin
      case (bus_addr)
         ADR_MODE: bus_rdata = DATA_W'(mode_q);
         ADR_CMPA: bus_rdata = DATA_W'(cmp_q[0]);
         ADR_CMPB: bus_rdata = DATA_W'(cmp_q[1]);
         ADR_PER:  bus_rdata = DATA_W'(per_q);
         ADR_CMD:  bus_rdata = DATA_W'(on_q);
         ADR_CNT:  bus_rdata = DATA_W'(cnt_o);
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wt_checker.sv
`timescale 1ns/1ps
module wt_checker #(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [2:0]        bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              wave_a_o,
   input logic              wave_b_o,
   input logic [CNT_W-1:0]  cnt_o,
   input logic              clk_on_o
);
   logic cmd_wr, cmd_sw, cmd_dis;
   assign cmd_wr  = bus_we && (bus_addr == 3'd4);
   assign cmd_sw  = cmd_wr && bus_wdata[2];
   assign cmd_dis = cmd_wr && bus_wdata[1];

   // R3: counter only steps by one or returns to zero
   a_r3_step_or_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o != $past(cnt_o)) |-> (cnt_o == '0 || cnt_o == $past(cnt_o) + 1'b1));

   // R5: software trigger zeroes the counter
   a_r5_trigger_restart: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_sw |=> (cnt_o == '0));

   // R7: disable command always stops the clock
   a_r7_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_dis |=> !clk_on_o);

   // R7: stopped counter holds without a trigger
   a_r7_stopped_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_on_o && !cmd_sw) |=> $stable(cnt_o));

   // R7: stopped outputs hold without a trigger
   a_r7_stopped_waves: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_on_o && !cmd_sw) |=> ($stable(wave_a_o) && $stable(wave_b_o)));
endmodule

bind wave_timer_ch wt_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .wave_a_o  (wave_a_o),
   .wave_b_o  (wave_b_o),
   .cnt_o     (cnt_o),
   .clk_on_o  (clk_on_o)
);

// File: tb/wave_timer_ch_tb_top.sv
`timescale 1ns/1ps
module wave_timer_ch_tb_top;
   localparam int CW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slow_clk = 1'b0;
   logic          bus_we = 1'b0;
   logic [2:0]    bus_addr = 3'd0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          wave_a_o, wave_b_o, clk_on_o;
   logic [CW-1:0] cnt_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   wave_timer_ch #(.CNT_W(CW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .wave_a_o(wave_a_o), .wave_b_o(wave_b_o),
      .cnt_o(cnt_o), .clk_on_o(clk_on_o)
   );

   // ---------------- reference model ----------------
   logic [15:0]   m_mode, m_ca, m_cb, m_per, m_cnt;
   logic [6:0]    m_pre;
   logic [2:0]    m_s;
   logic          m_on, m_wa, m_wb;

   function automatic logic apply(input logic [1:0] a, input logic q);
      if (a == 2'd1) return 1'b1;
      if (a == 2'd2) return 1'b0;
      if (a == 2'd3) return ~q;
      return q;
   endfunction

   always @(posedge clk) begin
      logic cmd, sw, tk, ph;
      logic [6:0] msk;
      if (!rst_n) begin
         m_mode = 0; m_ca = 0; m_cb = 0; m_per = 0; m_cnt = 0;
         m_pre = 0; m_s = 0; m_on = 0; m_wa = 0; m_wb = 0;
      end else begin
         cmd = bus_we && bus_addr == 3'd4;
         sw  = cmd && bus_wdata[2];
         if (m_mode[2]) tk = m_on && m_s[1] && !m_s[2];
         else begin
            msk = 7'((32'd1 << (2 * m_mode[1:0] + 1)) - 1);
            tk  = m_on && ((m_pre & msk) == msk);
         end
         ph = tk && (m_cnt == m_per);
         if (sw) begin
            m_wa = apply(m_mode[9:8], m_wa);
            m_wb = apply(m_mode[15:14], m_wb);
         end else begin
            if (ph)                       m_wa = apply(m_mode[7:6], m_wa);
            else if (tk && m_cnt == m_ca) m_wa = apply(m_mode[5:4], m_wa);
            if (ph)                       m_wb = apply(m_mode[13:12], m_wb);
            else if (tk && m_cnt == m_cb) m_wb = apply(m_mode[11:10], m_wb);
         end
         if (sw)      m_cnt = 0;
         else if (ph) m_cnt = 0;
         else if (tk) m_cnt = m_cnt + 1;
         if (sw)        m_pre = 0;
         else if (m_on) m_pre = m_pre + 1;
         m_s = {m_s[1:0], slow_clk};
         if (cmd) begin
            if (bus_wdata[1])      m_on = 0;
            else if (bus_wdata[0]) m_on = 1;
         end
         if (bus_we) begin
            case (bus_addr)
               3'd0: m_mode = bus_wdata[15:0];
               3'd1: m_ca   = bus_wdata[15:0];
               3'd2: m_cb   = bus_wdata[15:0];
               3'd3: m_per  = bus_wdata[15:0];
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] m_rdata(input logic [2:0] a);
      case (a)
         3'd0: return {16'd0, m_mode};
         3'd1: return {16'd0, m_ca};
         3'd2: return {16'd0, m_cb};
         3'd3: return {16'd0, m_per};
         3'd4: return {31'd0, m_on};
         3'd5: return {16'd0, m_cnt};
         default: return 32'd0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // per-cycle comparison against the model, away from both edges
   initial begin
      forever begin
         @(posedge clk);
         #1.5;
         if (rst_n) begin
            chk(cnt_o == m_cnt, "R3", "counter", cnt_o, m_cnt);
            chk(wave_a_o == m_wa, "R4", "output A", wave_a_o, m_wa);
            chk(wave_b_o == m_wb, "R4", "output B", wave_b_o, m_wb);
            chk(clk_on_o == m_on, "R7", "run flag", clk_on_o, m_on);
            chk(bus_rdata == m_rdata(bus_addr), "R1", "read data", bus_rdata, m_rdata(bus_addr));
         end
      end
   end

   // slow clock: 46 fast cycles per period, changed on falling edges
   initial begin
      forever begin
         repeat (23) @(negedge clk);
         slow_clk = ~slow_clk;
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      // R9: reset state
      chk(wave_a_o == 0 && wave_b_o == 0, "R9", "outputs in reset", {wave_a_o, wave_b_o}, 0);
      chk(cnt_o == 0, "R9", "counter in reset", cnt_o, 0);
      chk(clk_on_o == 0, "R9", "run flag in reset", clk_on_o, 0);
      chk(bus_rdata == 0, "R9", "mode in reset", bus_rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: writes truncated to counter width
      wr(3'd1, 32'h0001_2345);
      bus_addr = 3'd1; #0.1;
      chk(bus_rdata == 32'h2345, "R11", "compare A truncation", bus_rdata, 32'h2345);

      // R2: divide by 128, trigger and enable together
      wr(3'd3, 32'd1000);
      wr(3'd0, 32'd3);
      wr(3'd4, 32'd5);
      repeat (640) @(negedge clk);
      chk(cnt_o == 5, "R2", "count after 640 cycles at /128", cnt_o, 5);

      // R5: trigger only, applies trigger actions (A set, B clear)
      wr(3'd0, 32'h0000_8103);
      wr(3'd4, 32'd4);
      chk(cnt_o == 0, "R5", "counter after trigger", cnt_o, 0);
      chk(wave_a_o == 1, "R5", "A trigger set", wave_a_o, 1);
      chk(wave_b_o == 0, "R5", "B trigger clear", wave_b_o, 0);
      chk(clk_on_o == 1, "R5", "run flag kept", clk_on_o, 1);

      // R7: disable, then enable+disable together, then enable
      wr(3'd4, 32'd2);
      chk(clk_on_o == 0, "R7", "disable", clk_on_o, 0);
      wr(3'd4, 32'd3);
      chk(clk_on_o == 0, "R7", "disable wins over enable", clk_on_o, 0);
      wr(3'd4, 32'd1);
      chk(clk_on_o == 1, "R7", "enable", clk_on_o, 1);

      // R6: both match actions none, trigger sets A and clears B
      wr(3'd1, 32'd3);
      wr(3'd3, 32'd9);
      wr(3'd0, 32'h0000_8100);
      wr(3'd4, 32'd5);
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         chk(wave_a_o == 1 && wave_b_o == 0, "R6", "held levels",
             {wave_a_o, wave_b_o}, 2'b10);
      end

      // R8: compare A equals period, period action set beats compare clear
      wr(3'd1, 32'd4);
      wr(3'd3, 32'd4);
      wr(3'd0, 32'h0000_0260);
      wr(3'd4, 32'd4);
      chk(wave_a_o == 0, "R8", "A after trigger clear", wave_a_o, 0);
      repeat (40) @(negedge clk);
      chk(wave_a_o == 1, "R8", "period set wins", wave_a_o, 1);

      // R10: slow clock ticks
      wr(3'd3, 32'd1000);
      wr(3'd0, 32'd4);
      wr(3'd4, 32'd5);
      repeat (200) @(negedge clk);
      chk(cnt_o >= 4 && cnt_o <= 5, "R10", "slow ticks in 200 cycles", cnt_o, 4);
      chk(cnt_o == m_cnt, "R10", "slow count vs model", cnt_o, m_cnt);

      // random phase: R1 R3 R4 R5 R7 R8 checked every cycle against the model
      for (int c = 0; c < 30000; c++) begin
         int r;
         r = int'($urandom % 32);
         if (r == 0) begin
            logic [2:0] cm;
            cm = 3'($urandom % 8);
            wr(3'd4, {29'd0, cm});
         end else if (r <= 3) begin
            logic [2:0] a;
            logic [31:0] d;
            a = 3'($urandom % 4);
            if (a == 3'd0) d = {$urandom} & 32'h0000_FFF9;
            else           d = $urandom % 24;
            wr(a, d);
         end else begin
            @(negedge clk);
            bus_addr = 3'($urandom % 8);
         end
      end

      done = 1;
      finish_run();
   end
endmodule